// File: doc/BRIEF.md
# Host Command Mailbox and Doorbell Register Block

This block sits on the controller side of a host-facing byte-addressed register bus. The host writes a thirteen-byte command into a mailbox window. It then rings the inbound doorbell to post the command. The posted bytes stay on a parallel output for an internal command consumer. The block reports "full" until that consumer pulses a take strobe.

In the other direction, an internal completion source delivers a slot identifier and a 16-bit status word. The block latches them and raises a status-available flag in the outbound doorbell. When enabled, it also drives an interrupt. The host reads the result and clears the flag. It then acknowledges through the inbound doorbell.

The same doorbell also carries an init-busy indication and two self-clearing handshake bits, SACK and RESET. A separate latched firmware-error register, with two parameter bytes, completes the block.

Register map (byte addresses):

| Address | Contents |
|---|---|
| 0x00 to 0x0C | mailbox bytes |
| 0x0D | inbound doorbell |
| 0x0E | outbound doorbell |
| 0x0F | interrupt enable |
| 0x10 | slot identifier |
| 0x11 | status, low byte |
| 0x12 | status, high byte |
| 0x13 | firmware error code |
| 0x14 | error parameter 1 |
| 0x15 | error parameter 2 |

Any other address reads 0.

Top module: `cmd_mailbox_if`

## Requirements
- R1: A write to addresses 0x00 to 0x0C stores that mailbox byte and appears on `cons_cmd` (byte k at bits 8k+7:8k) while no command is posted. Mailbox writes while a command is posted are ignored.
- R2: Writing 1 to bit 0 of the inbound doorbell (0x0D) posts the command. Bit 0 then reads 1 and `cons_cmd_valid` is high. A `cons_take` pulse while posted clears both. A take while nothing is posted has no effect.
- R3: While `cpl_ready` is high, a `cpl_valid` cycle latches the completion, and the following cycle shows it. Bit 0 of the outbound doorbell (0x0E) reads 1, 0x10 reads the slot, and 0x11/0x12 read the status low and high bytes.
- R4: While status-available is set, `cpl_ready` is low and `cpl_valid` is ignored. The slot and status registers keep their values.
- R5: Writing a byte with bit 0 set to 0x0E clears status-available. Writing a byte with bit 0 clear leaves it set.
- R6: Writing 1 to bit 1 of 0x0D (SACK) makes that bit read 1 for exactly SACK_CYCLES cycles, after which it clears by itself.
- R7: Writing 1 to bit 2 of 0x0D (RESET) makes that bit and `soft_reset` read 1 for exactly RESET_CYCLES cycles, after which both clear by themselves.
- R8: Bit 3 of 0x0D (init busy) reads 1 from reset until an `init_done` pulse. It then reads 0 until the next reset.
- R9: A `fw_err_valid` cycle with no error pending latches the code into 0x13 with bit 2 (pending) forced to 1, and the parameters into 0x14 and 0x15.
- R10: While an error is pending, further `fw_err_valid` events are ignored. Writing 0 to 0x13 clears all three error registers, and writing a nonzero value to 0x13 changes nothing.
- R11: A nonzero write to 0x0F enables the interrupt and a zero write disables it. 0x0F reads the enable as bit 0.
- R12: `irq` equals status-available AND enable, delayed by one register stage.
- R13: After reset every register reads 0 except 0x0D, which reads 0x08. `irq`, `cons_cmd_valid` and `soft_reset` are 0 and `cpl_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 5 | register byte address |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data for reg_addr (combinational) |
| irq | output | 1 | interrupt to host |
| cons_cmd_valid | output | 1 | a command is posted |
| cons_cmd | output | 104 | posted mailbox bytes, byte 0 in the low bits |
| cons_take | input | 1 | consumer has taken the command |
| cpl_valid | input | 1 | completion offered |
| cpl_slot | input | 8 | completed slot identifier |
| cpl_status | input | 16 | completion status word |
| cpl_ready | output | 1 | block can accept a completion |
| init_done | input | 1 | controller initialisation finished |
| fw_err_valid | input | 1 | firmware error event |
| fw_err_code | input | 8 | error code (bit 2 is replaced by pending) |
| fw_err_p1 | input | 8 | error parameter 1 |
| fw_err_p2 | input | 8 | error parameter 2 |
| soft_reset | output | 1 | RESET handshake in progress |

## Verification
The bench builds the block with SACK_CYCLES set to 4 and RESET_CYCLES set to 6 instead of the large defaults. This lets it check, within a few cycles, the exact cycle at which each handshake bit self-clears. Randomised mailbox contents, slot identifiers, status words and error codes from a fixed seed exercise every byte lane of the data paths. Directed cases cover posting while full, take with nothing posted, a completion offered while one is pending, clear writes of the wrong value, and the interrupt both gated and ungated.

// File: rtl/mbox_pkg.sv
// Shared address map and bit positions for the command mailbox block.
// Assumes a 5-bit byte address; mailbox occupies the lowest addresses.
package mbox_pkg;
    localparam int          MBOX_BYTES = 13;
    localparam int          ADDR_W     = 5;
    localparam logic [4:0]  A_IDB      = 5'h0D;
    localparam logic [4:0]  A_ODB      = 5'h0E;
    localparam logic [4:0]  A_IE       = 5'h0F;
    localparam logic [4:0]  A_SLOT     = 5'h10;
    localparam logic [4:0]  A_STLO     = 5'h11;
    localparam logic [4:0]  A_STHI     = 5'h12;
    localparam logic [4:0]  A_ERR      = 5'h13;
    localparam logic [4:0]  A_EP1      = 5'h14;
    localparam logic [4:0]  A_EP2      = 5'h15;
    localparam int          IDB_FULL   = 0;
    localparam int          IDB_SACK   = 1;
    localparam int          IDB_RST    = 2;
    localparam int          ERR_PEND   = 2;
endpackage

// File: rtl/mbox_cmd_store.sv
// Mailbox byte store plus the posted ("full") flag.
// Assumes byte_we is already decoded to a mailbox address; writes are
// dropped while a command is posted so the consumer sees stable bytes.
module mbox_cmd_store #(
    parameter int NB    = 13,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_we,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       wdata,
    input  logic             post,
    input  logic             take,
    output logic             full,
    output logic [7:0]       bytes_q [NB]
);
    // Store mailbox bytes while no command is posted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) bytes_q[i] <= '0;
        end else if (byte_we && !full) begin
            bytes_q[byte_idx] <= wdata;
        end
    end

    // Posted flag: set by the doorbell, cleared by the consumer take.
    always_ff @(posedge clk) begin
        if (!rst_n)              full <= 1'b0;
        else if (take && full)   full <= 1'b0;
        else if (post)           full <= 1'b1;
    end
endmodule

// File: rtl/mbox_selfclear.sv
// A bit that reads 1 for exactly LEN cycles after a start pulse.
// Assumes LEN >= 1; a new start reloads the count.
module mbox_selfclear #(
    parameter int LEN = 4,
    localparam int CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(LEN);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/mbox_cpl_regs.sv
// Completion capture: slot, status and status-available flag.
// Assumes the offered completion is held off (ready low) while a previous
// one is still unacknowledged; the clear request wins over nothing else.
module mbox_cpl_regs #(
    parameter int SLOT_W = 8,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpl_valid,
    input  logic [SLOT_W-1:0] cpl_slot,
    input  logic [STAT_W-1:0] cpl_status,
    input  logic              clr,
    output logic              savail,
    output logic              ready,
    output logic [SLOT_W-1:0] slot_q,
    output logic [STAT_W-1:0] status_q
);
    assign ready = !savail;

    // Latch a completion when free; clear on host acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            savail   <= 1'b0;
            slot_q   <= '0;
            status_q <= '0;
        end else if (cpl_valid && ready) begin
            savail   <= 1'b1;
            slot_q   <= cpl_slot;
            status_q <= cpl_status;
        end else if (clr) begin
            savail   <= 1'b0;
        end
    end
endmodule

// File: rtl/mbox_fwerr_regs.sv
// Firmware error latch: code with pending bit, and two parameter bytes.
// Assumes only the first error is kept until the host clears it.
module mbox_fwerr_regs #(
    parameter int PEND_BIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_valid,
    input  logic [7:0] err_code,
    input  logic [7:0] err_p1,
    input  logic [7:0] err_p2,
    input  logic       clr,
    output logic       pend,
    output logic [7:0] code_q,
    output logic [7:0] p1_q,
    output logic [7:0] p2_q
);
    assign pend = code_q[PEND_BIT];

    // Host clear has priority; otherwise capture when nothing is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code_q <= '0;
            p1_q   <= '0;
            p2_q   <= '0;
        end else if (err_valid && !pend) begin
            code_q           <= err_code;
            code_q[PEND_BIT] <= 1'b1;
            p1_q             <= err_p1;
            p2_q             <= err_p2;
        end
    end
endmodule

// File: rtl/cmd_mailbox_if.sv
// Host command mailbox and doorbell register block.
// Decodes byte-wide register writes, muxes reads combinationally, and ties
// together the command store, completion capture, error latch, the two
// self-clearing handshake bits, init-busy and the gated interrupt.
module cmd_mailbox_if
    import mbox_pkg::*;
#(
    parameter int SACK_CYCLES  = 1000,
    parameter int RESET_CYCLES = 5000,
    localparam int IDX_W       = $clog2(MBOX_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    output logic                    irq,
    output logic                    cons_cmd_valid,
    output logic [MBOX_BYTES*8-1:0] cons_cmd,
    input  logic                    cons_take,
    input  logic                    cpl_valid,
    input  logic [7:0]              cpl_slot,
    input  logic [15:0]             cpl_status,
    output logic                    cpl_ready,
    input  logic                    init_done,
    input  logic                    fw_err_valid,
    input  logic [7:0]              fw_err_code,
    input  logic [7:0]              fw_err_p1,
    input  logic [7:0]              fw_err_p2,
    output logic                    soft_reset
);
    logic       full, savail, sack_busy, rst_busy, init_busy, ie_q;
    logic       fwerr_pend;
    logic [7:0] mbox_q [MBOX_BYTES];
    logic [7:0] slot_q, err_q, ep1_q, ep2_q;
    logic [15:0] status_q;

    // Write decode.
    logic wr_idb, post, sack_go, rst_go, odb_clr, fwerr_clr, mbox_we;
    assign mbox_we   = reg_wr && (reg_addr < ADDR_W'(MBOX_BYTES));
    assign wr_idb    = reg_wr && (reg_addr == A_IDB);
    assign post      = wr_idb && reg_wdata[IDB_FULL];
    assign sack_go   = wr_idb && reg_wdata[IDB_SACK];
    assign rst_go    = wr_idb && reg_wdata[IDB_RST];
    assign odb_clr   = reg_wr && (reg_addr == A_ODB) && reg_wdata[0];
    assign fwerr_clr = reg_wr && (reg_addr == A_ERR) && (reg_wdata == 8'h00);

    mbox_cmd_store #(.NB(MBOX_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .byte_we(mbox_we),
        .byte_idx(reg_addr[IDX_W-1:0]), .wdata(reg_wdata),
        .post(post), .take(cons_take), .full(full), .bytes_q(mbox_q)
    );

    mbox_selfclear #(.LEN(SACK_CYCLES)) u_sack (
        .clk(clk), .rst_n(rst_n), .start(sack_go), .busy(sack_busy)
    );

    mbox_selfclear #(.LEN(RESET_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .start(rst_go), .busy(rst_busy)
    );

    mbox_cpl_regs #(.SLOT_W(8), .STAT_W(16)) u_cpl (
        .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_slot(cpl_slot),
        .cpl_status(cpl_status), .clr(odb_clr), .savail(savail),
        .ready(cpl_ready), .slot_q(slot_q), .status_q(status_q)
    );

    mbox_fwerr_regs #(.PEND_BIT(ERR_PEND)) u_err (
        .clk(clk), .rst_n(rst_n), .err_valid(fw_err_valid),
        .err_code(fw_err_code), .err_p1(fw_err_p1), .err_p2(fw_err_p2),
        .clr(fwerr_clr), .pend(fwerr_pend), .code_q(err_q),
        .p1_q(ep1_q), .p2_q(ep2_q)
    );

    // Flatten the mailbox for the consumer.
    for (genvar g = 0; g < MBOX_BYTES; g++) begin : g_flat
        assign cons_cmd[g*8 +: 8] = mbox_q[g];
    end
    assign cons_cmd_valid = full;
    assign soft_reset     = rst_busy;

    // Init-busy: set out of reset, cleared once by init_done.
    always_ff @(posedge clk) begin
        if (!rst_n)          init_busy <= 1'b1;
        else if (init_done)  init_busy <= 1'b0;
    end

    // Interrupt enable register: any nonzero write enables.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ie_q <= 1'b0;
        else if (reg_wr && reg_addr == A_IE)   ie_q <= (reg_wdata != 8'h00);
    end

    // Registered interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= savail && ie_q;
    end

    // Read mux.
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr < ADDR_W'(MBOX_BYTES)) begin
            reg_rdata = mbox_q[reg_addr[IDX_W-1:0]];
        end else begin
            case (reg_addr)
                A_IDB:   reg_rdata = {4'b0, init_busy, rst_busy, sack_busy, full};
                A_ODB:   reg_rdata = {7'b0, savail};
                A_IE:    reg_rdata = {7'b0, ie_q};
                A_SLOT:  reg_rdata = slot_q;
                A_STLO:  reg_rdata = status_q[7:0];
                A_STHI:  reg_rdata = status_q[15:8];
                A_ERR:   reg_rdata = err_q;
                A_EP1:   reg_rdata = ep1_q;
                A_EP2:   reg_rdata = ep2_q;
                default: reg_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/cmd_mailbox_if_chk.sv
// Property checker for cmd_mailbox_if, attached by bind below.
// Assumes the internal names savail, ie_q, full, init_busy, odb_clr,
// slot_q, fwerr_pend and fwerr_clr in the top module.
module cmd_mailbox_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       savail,
    input logic       ie_q,
    input logic       irq,
    input logic       full,
    input logic       cons_take,
    input logic       cpl_valid,
    input logic       cpl_ready,
    input logic [7:0] slot_q,
    input logic       odb_clr,
    input logic       init_busy,
    input logic       init_done,
    input logic       fwerr_pend,
    input logic       fwerr_clr
);
    // R12
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (savail && ie_q) |=> irq);
    // R12
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(savail && ie_q) |=> !irq);
    // R4
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (savail && !odb_clr) |=> (savail && $stable(slot_q)));
    // R3
    cpl_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> savail);
    // R2
    take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && cons_take) |=> !full);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && !init_done) |=> init_busy);
    // R8
    busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_busy |=> !init_busy);
    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwerr_pend && !fwerr_clr) |=> fwerr_pend);
endmodule

bind cmd_mailbox_if cmd_mailbox_if_chk u_chk (
    .clk(clk), .rst_n(rst_n), .savail(savail), .ie_q(ie_q), .irq(irq),
    .full(full), .cons_take(cons_take), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .slot_q(slot_q), .odb_clr(odb_clr),
    .init_busy(init_busy), .init_done(init_done),
    .fwerr_pend(fwerr_pend), .fwerr_clr(fwerr_clr)
);

// File: tb/tb_cmd_mailbox_if.sv
// Self-checking bench: seeded random data with directed corner cases.
module tb_cmd_mailbox_if;
    localparam int CLK_P  = 10;
    localparam int SACK_N = 4;
    localparam int RST_N  = 6;
    localparam int NB     = 13;

    logic          clk = 0, rst_n = 0;
    logic          reg_wr = 0;
    logic [4:0]    reg_addr = 0;
    logic [7:0]    reg_wdata = 0, reg_rdata;
    logic          irq, cons_cmd_valid, cons_take = 0;
    logic [NB*8-1:0] cons_cmd;
    logic          cpl_valid = 0, cpl_ready;
    logic [7:0]    cpl_slot = 0;
    logic [15:0]   cpl_status = 0;
    logic          init_done = 0, fw_err_valid = 0, soft_reset;
    logic [7:0]    fw_err_code = 0, fw_err_p1 = 0, fw_err_p2 = 0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    cmd_mailbox_if #(.SACK_CYCLES(SACK_N), .RESET_CYCLES(RST_N)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .cons_cmd_valid(cons_cmd_valid), .cons_cmd(cons_cmd),
        .cons_take(cons_take), .cpl_valid(cpl_valid), .cpl_slot(cpl_slot),
        .cpl_status(cpl_status), .cpl_ready(cpl_ready), .init_done(init_done),
        .fw_err_valid(fw_err_valid), .fw_err_code(fw_err_code),
        .fw_err_p1(fw_err_p1), .fw_err_p2(fw_err_p2), .soft_reset(soft_reset)
    );

    // Expected inbound doorbell value from its four flags.
    function automatic logic [7:0] exp_idb(bit f, bit s, bit r, bit b);
        return {4'b0, b, r, s, f};
    endfunction

    // Expected error register from a raw code.
    function automatic logic [7:0] exp_err(logic [7:0] c);
        return c | 8'h04;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    task automatic cpl(logic [7:0] sl, logic [15:0] st);
        @(negedge clk);
        cpl_valid = 1; cpl_slot = sl; cpl_status = st;
        @(negedge clk);
        cpl_valid = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] mb [NB];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R13: reset state of every address.
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            chk("R13 reset read", v, (a == 13) ? 8'h08 : 8'h00);
        end
        chk("R13 irq", irq, 0);
        chk("R13 cons_cmd_valid", cons_cmd_valid, 0);
        chk("R13 soft_reset", soft_reset, 0);
        chk("R13 cpl_ready", cpl_ready, 1);

        // R8: init busy cleared by init_done, sticky afterwards.
        repeat (3) @(negedge clk);
        rd(5'h0D, v); chk("R8 busy before done", v, exp_idb(0,0,0,1));
        pulse(init_done);
        rd(5'h0D, v); chk("R8 busy after done", v, exp_idb(0,0,0,0));
        repeat (2) @(negedge clk);
        rd(5'h0D, v); chk("R8 busy stays clear", v, exp_idb(0,0,0,0));

        // R1, R2: random mailbox contents, post, overwrite attempt, take.
        for (int it = 0; it < 4; it++) begin
            for (int b = 0; b < NB; b++) begin
                mb[b] = 8'($urandom);
                wr(5'(b), mb[b]);
            end
            for (int b = 0; b < NB; b++)
                chk("R1 cons_cmd byte", cons_cmd[b*8 +: 8], mb[b]);
            rd(5'(it), v); chk("R1 mailbox readback", v, mb[it]);
            wr(5'h0D, 8'h01);
            rd(5'h0D, v); chk("R2 full bit", v, exp_idb(1,0,0,0));
            chk("R2 cons_cmd_valid", cons_cmd_valid, 1);
            wr(5'(it), ~mb[it]);
            chk("R1 write while full ignored", cons_cmd[it*8 +: 8], mb[it]);
            wr(5'h0D, 8'h01);
            chk("R2 repost keeps full", cons_cmd_valid, 1);
            pulse(cons_take);
            rd(5'h0D, v); chk("R2 take clears full", v, exp_idb(0,0,0,0));
            chk("R2 cons_cmd_valid low", cons_cmd_valid, 0);
        end
        pulse(cons_take);
        chk("R2 take while empty", cons_cmd_valid, 0);

        // R11: interrupt enable register.
        wr(5'h0F, 8'h80);
        rd(5'h0F, v); chk("R11 nonzero enables", v, 8'h01);
        wr(5'h0F, 8'h00);
        rd(5'h0F, v); chk("R11 zero disables", v, 8'h00);

        // R3, R4, R5, R12: completions, with interrupt disabled on pass 0.
        for (int it = 0; it < 5; it++) begin
            logic [7:0]  sl;
            logic [15:0] st;
            bit en;
            en = (it != 0);
            wr(5'h0F, en ? 8'($urandom | 1) : 8'h00);
            sl = 8'($urandom);
            st = 16'($urandom);
            cpl(sl, st);
            rd(5'h0E, v);  chk("R3 status available", v, 8'h01);
            rd(5'h10, v);  chk("R3 slot", v, sl);
            rd(5'h11, v);  chk("R3 status low", v, st[7:0]);
            rd(5'h12, v);  chk("R3 status high", v, st[15:8]);
            chk("R12 irq one stage late", irq, 0);
            @(negedge clk);
            chk("R12 irq gated", irq, en);
            chk("R4 ready low", cpl_ready, 0);
            cpl(~sl, ~st);
            rd(5'h10, v);  chk("R4 slot held", v, sl);
            rd(5'h11, v);  chk("R4 status held", v, st[7:0]);
            wr(5'h0E, 8'hFE);
            rd(5'h0E, v);  chk("R5 bit0 clear write ignored", v, 8'h01);
            wr(5'h0E, 8'h01);
            rd(5'h0E, v);  chk("R5 cleared", v, 8'h00);
            chk("R12 irq still registered", irq, en);
            @(negedge clk);
            chk("R12 irq drops", irq, 0);
            chk("R3 ready again", cpl_ready, 1);
        end

        // R6: SACK self-clears after exactly SACK_N cycles.
        wr(5'h0D, 8'h02);
        rd(5'h0D, v); chk("R6 SACK set", v, exp_idb(0,1,0,0));
        repeat (SACK_N - 1) @(negedge clk);
        rd(5'h0D, v); chk("R6 SACK last cycle", v, exp_idb(0,1,0,0));
        @(negedge clk);
        rd(5'h0D, v); chk("R6 SACK cleared", v, exp_idb(0,0,0,0));

        // R7: RESET self-clears after exactly RST_N cycles.
        wr(5'h0D, 8'h04);
        rd(5'h0D, v); chk("R7 RESET set", v, exp_idb(0,0,1,0));
        chk("R7 soft_reset high", soft_reset, 1);
        repeat (RST_N - 1) @(negedge clk);
        chk("R7 soft_reset last cycle", soft_reset, 1);
        @(negedge clk);
        rd(5'h0D, v); chk("R7 RESET cleared", v, exp_idb(0,0,0,0));
        chk("R7 soft_reset low", soft_reset, 0);

        // R9, R10: firmware error latch.
        for (int it = 0; it < 3; it++) begin
            logic [7:0] c, p1, p2;
            c = 8'($urandom); p1 = 8'($urandom); p2 = 8'($urandom);
            @(negedge clk);
            fw_err_valid = 1; fw_err_code = c; fw_err_p1 = p1; fw_err_p2 = p2;
            @(negedge clk);
            fw_err_code = ~c; fw_err_p1 = ~p1; fw_err_p2 = ~p2;
            rd(5'h13, v); chk("R9 error code with pending", v, exp_err(c));
            rd(5'h14, v); chk("R9 param1", v, p1);
            rd(5'h15, v); chk("R9 param2", v, p2);
            @(negedge clk);
            fw_err_valid = 0;
            rd(5'h13, v); chk("R10 second error ignored", v, exp_err(c));
            rd(5'h14, v); chk("R10 param1 kept", v, p1);
            wr(5'h13, 8'h04);
            rd(5'h13, v); chk("R10 nonzero write ignored", v, exp_err(c));
            wr(5'h13, 8'h00);
            rd(5'h13, v); chk("R10 cleared code", v, 8'h00);
            rd(5'h15, v); chk("R10 cleared param2", v, 8'h00);
        end

        finish_run();
    end
endmodule